// File: doc/BRIEF.md
# DMA Global Interrupt and Channel Start Control

This block holds the shared control state of a seven-channel DMA controller. It keeps a channel priority/enable word and an interrupt control word, and it stores one control word per channel. When software writes a channel control word, the block decides in the same cycle whether that channel should run, and it emits a one-cycle start pulse that an external transfer engine consumes. The sequencing of the transfers themselves is done elsewhere.

When a channel finishes, its engine sends a one-cycle done pulse. That pulse clears the channel's run bit and may latch a completion flag. The interrupt word combines plain read/write fields with completion flags that are cleared by writing ones. A summary bit in the interrupt word follows the master interrupt condition. The single request toward the system interrupt controller pulses only when that summary bit goes from clear to set, so a condition that stays active raises one request and no more.

All registers sit behind a single-cycle write port and a combinational read port, selected by a small register index. Index 0 to 6 selects the channel control words, 7 the priority word and 8 the interrupt word. Channel 5 is a hole: its control word cannot be written and the channel never starts.

Top module: `dmac_glue_ctrl`

## Requirements
- R1: After reset every channel control word and the interrupt word read 0, the priority word reads 0x07654321, and start_o and irq_o are low.
- R2: A write to index 7 stores all 32 bits of the priority word, which reads back unchanged.
- R3: A write to the interrupt word (index 8) takes bits 0-5, bit 15 (bus error), bits 16-22 (per-channel flag enables) and bit 23 (global enable) from the data; every other bit outside the flags and the summary bit reads 0.
- R4: Flag bits 24-30 of the interrupt word are cleared where a 1 is written and kept where a 0 is written.
- R5: A done pulse on done_i[n] sets flag bit 24+n only while enable bit 16+n is set (using the value after any same-cycle write); when a set and a clear land on the same flag in the same cycle, the set wins.
- R6: Bit 31 of the interrupt word equals (bit 23 AND any of bits 24-30) OR bit 15, evaluated on the value stored at the same clock edge, so it also drops when the condition goes away.
- R7: irq_o is high for exactly one cycle, the cycle right after the edge at which bit 31 changes from 0 to 1, and stays low while bit 31 remains 1.
- R8: A write to channel index n (n other than 5) stores the data word; start_o[n] is high for the one cycle after that edge exactly when data bit 24 is 1 and priority bit 3+4n is 1.
- R9: done_i[n] clears bit 24 of channel n's control word; a write to that word in the same cycle takes precedence.
- R10: Channel index 5 ignores writes: its control word always reads 0 and start_o[5] never rises.
- R11: Reads of indexes 9 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register index for the read |
| rd_data | output | 32 | Combinational read data |
| done_i | input | 7 | Per-channel completion pulses |
| start_o | output | 7 | Per-channel one-cycle start pulses |
| irq_o | output | 1 | One-cycle request to the interrupt controller |

## Verification
Every stored value changes at the clock edge that captures the write or done pulse, and rd_data follows combinationally, so the bench reads registers in the same cycle, one time step after that edge. start_o and irq_o are registered from the same edge and are therefore due in exactly the cycle after the capturing edge; the bench samples them one step after that edge and then checks them low again on the next cycle. Each stimulus cycle updates an arithmetic model in the bench that sweeps every channel against enabled and disabled priority bits and every flag against set and clear enables.

// File: rtl/dmac_glue_pkg.sv
package dmac_glue_pkg;
  localparam int REG_W     = 32;
  localparam int START_BIT = 24;
  localparam int FLAG_LSB  = 24;
  localparam int EN_LSB    = 16;
  localparam int GEN_BIT   = 23;
  localparam int BERR_BIT  = 15;
  localparam int SENT_BIT  = 31;
  localparam logic [REG_W-1:0] IRQ_RW_MASK   = 32'h00FF_803F;
  localparam logic [REG_W-1:0] IRQ_FLAG_MASK = 32'h7F00_0000;

  // Plain fields come from the data, flags are write-one-to-clear.
  function automatic logic [REG_W-1:0] irq_merge(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] wdat);
    return (wdat & IRQ_RW_MASK) | (cur & ~wdat & IRQ_FLAG_MASK);
  endfunction

  function automatic logic master_cond(input logic [REG_W-1:0] r);
    return (r[GEN_BIT] && (r[30:24] != 7'd0)) || r[BERR_BIT];
  endfunction

  function automatic logic start_decide(input logic wr_stb,
                                        input logic run_bit,
                                        input logic chan_en);
    return wr_stb && run_bit && chan_en;
  endfunction
endpackage

// File: rtl/dmac_prio_reg.sv
module dmac_prio_reg #(
  parameter int          W         = 32,
  parameter logic [31:0] RESET_VAL = 32'h0765_4321
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] prio_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      prio_q <= RESET_VAL[W-1:0];
    else if (wr_stb) prio_q <= wr_data;
  end
endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl
  import dmac_glue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  input  logic             chan_en,
  input  logic             done,
  output logic [REG_W-1:0] ctrl_q,
  output logic             start_o
);
  logic go_now;
  assign go_now = start_decide(wr_stb, wr_data[START_BIT], chan_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= go_now;
      if (wr_stb)    ctrl_q <= wr_data;
      else if (done) ctrl_q[START_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl
  import dmac_glue_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0] done_i,
  output logic [REG_W-1:0]  irq_q,
  output logic              irq_o
);
  logic [REG_W-1:0]  base_v;
  logic [REG_W-1:0]  next_v;
  logic [NUM_CH-1:0] flag_set;
  logic              raise_evt;

  always_comb begin
    base_v   = wr_stb ? irq_merge(irq_q, wr_data) : irq_q;
    flag_set = done_i & base_v[EN_LSB +: NUM_CH];
    next_v   = base_v;
    next_v[FLAG_LSB +: NUM_CH] = base_v[FLAG_LSB +: NUM_CH] | flag_set;
    next_v[SENT_BIT] = master_cond(next_v);
    raise_evt = next_v[SENT_BIT] && !irq_q[SENT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_q <= next_v;
      irq_o <= raise_evt;
    end
  end
endmodule

// File: rtl/dmac_glue_ctrl.sv
module dmac_glue_ctrl
  import dmac_glue_pkg::*;
#(
  parameter int          NUM_CH     = 7,
  parameter int          SKIP_CH    = 5,
  parameter int          AW         = 4,
  parameter logic [31:0] PRIO_RESET = 32'h0765_4321
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] start_o,
  output logic              irq_o
);
  localparam logic [AW-1:0] PRIO_IDX = AW'(NUM_CH);
  localparam logic [AW-1:0] IRQ_IDX  = AW'(NUM_CH + 1);

  logic [NUM_CH-1:0][REG_W-1:0] ctrl_q;
  logic [REG_W-1:0]             prio_q;
  logic [REG_W-1:0]             irq_q;
  logic [NUM_CH-1:0]            ch_wr;
  logic                         prio_wr;
  logic                         irq_wr;

  assign prio_wr = wr_en && (wr_addr == PRIO_IDX);
  assign irq_wr  = wr_en && (wr_addr == IRQ_IDX);

  dmac_prio_reg #(.W(REG_W), .RESET_VAL(PRIO_RESET)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_stb(prio_wr), .wr_data(wr_data), .prio_q(prio_q)
  );

  dmac_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_stb(irq_wr), .wr_data(wr_data),
    .done_i(done_i), .irq_q(irq_q), .irq_o(irq_o)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign ch_wr[n] = wr_en && (wr_addr == AW'(n));
    if (n == SKIP_CH) begin : g_hole
      assign ctrl_q[n]  = '0;
      assign start_o[n] = 1'b0;
    end else begin : g_live
      dmac_chan_ctrl u_chan (
        .clk(clk), .rst_n(rst_n), .wr_stb(ch_wr[n]), .wr_data(wr_data),
        .chan_en(prio_q[3 + 4*n]), .done(done_i[n]),
        .ctrl_q(ctrl_q[n]), .start_o(start_o[n])
      );
    end
  end

  always_comb begin
    rd_data = '0;
    for (int n = 0; n < NUM_CH; n++)
      if (rd_addr == AW'(n)) rd_data = ctrl_q[n];
    if (rd_addr == PRIO_IDX) rd_data = prio_q;
    if (rd_addr == IRQ_IDX)  rd_data = irq_q;
  end
endmodule

// File: rtl/dmac_glue_ctrl_chk.sv
module dmac_glue_ctrl_chk #(
  parameter int NUM_CH  = 7,
  parameter int SKIP_CH = 5,
  parameter int AW      = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [AW-1:0]            wr_addr,
  input logic                     wr_go,
  input logic [NUM_CH-1:0]        done_i,
  input logic [NUM_CH-1:0]        start_o,
  input logic                     irq_o,
  input logic                     irq_sent,
  input logic [NUM_CH-1:0]        irq_flags,
  input logic [NUM_CH-1:0][31:0]  ctrl_q
);
  assert_start_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  assert_start_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |-> ($past(wr_en) && $past(wr_go)));

  assert_skip_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o[SKIP_CH] && (ctrl_q[SKIP_CH] == 32'd0));

  assert_irq_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_sent && !$past(irq_sent)));

  assert_rise_gives_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sent) |-> irq_o);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_flag_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flags & ~$past(irq_flags)) != '0) |-> ($past(done_i) != '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done_i[n]) && !$past(wr_en && (wr_addr == AW'(n)))) |-> !ctrl_q[n][24]);

    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && (wr_addr == AW'(n))) |->
        ((ctrl_q[n] & ~32'h0100_0000) == ($past(ctrl_q[n]) & ~32'h0100_0000)));
  end
endmodule

bind dmac_glue_ctrl dmac_glue_ctrl_chk #(.NUM_CH(NUM_CH), .SKIP_CH(SKIP_CH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_go(wr_data[dmac_glue_pkg::START_BIT]), .done_i(done_i), .start_o(start_o),
  .irq_o(irq_o), .irq_sent(irq_q[dmac_glue_pkg::SENT_BIT]),
  .irq_flags(irq_q[dmac_glue_pkg::FLAG_LSB +: NUM_CH]), .ctrl_q(ctrl_q)
);

// File: tb/dmac_glue_ctrl_tb_top.sv
module dmac_glue_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [6:0]  done_i;
  logic [6:0]  start_o;
  logic        irq_o;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_ctrl [7];
  logic [31:0] m_prio;
  logic [31:0] m_irq;

  always #5 clk = ~clk;

  dmac_glue_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done_i(done_i), .start_o(start_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input int idx, input logic [31:0] exp);
    rd_addr = idx[3:0];
    #1;
    chk(tag, $sformatf("read idx %0d", idx), rd_data, exp);
  endtask

  // One stimulus cycle: drive at negedge, update model, sample after posedge.
  task automatic step(input string tag, input logic wen, input int idx,
                      input logic [31:0] data, input logic [6:0] done);
    logic [6:0]  exp_start;
    logic        exp_irq;
    logic        old_sent;
    logic [31:0] nv;
    @(negedge clk);
    wr_en = wen; wr_addr = idx[3:0]; wr_data = data; done_i = done;
    exp_start = '0;
    old_sent  = m_irq[31];
    nv        = m_irq;
    if (wen) begin
      if (idx < 7 && idx != 5) begin
        m_ctrl[idx] = data;
        exp_start[idx] = data[24] & m_prio[3 + 4*idx];
      end else if (idx == 7) begin
        m_prio = data;
      end else if (idx == 8) begin
        nv = 32'd0;
        nv[5:0]   = data[5:0];
        nv[15]    = data[15];
        nv[23:16] = data[23:16];
        for (int k = 24; k <= 30; k++) nv[k] = m_irq[k] && !data[k];
      end
    end
    for (int n = 0; n < 7; n++) begin
      if (done[n]) begin
        if (nv[16+n]) nv[24+n] = 1'b1;
        if (!(wen && idx == n) && n != 5) m_ctrl[n][24] = 1'b0;
      end
    end
    nv[31] = (nv[23] && (nv[30:24] != 7'd0)) || nv[15];
    exp_irq = nv[31] && !old_sent;
    m_irq = nv;
    @(posedge clk);
    #1;
    chk(tag, "start_o", {25'd0, start_o}, {25'd0, exp_start});
    chk(tag, "irq_o", {31'd0, irq_o}, {31'd0, exp_irq});
    wr_en = 1'b0; done_i = '0;
    read_chk(tag, 8, m_irq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; done_i = '0;
    for (int n = 0; n < 7; n++) m_ctrl[n] = 32'd0;
    m_prio = 32'h0765_4321;
    m_irq  = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R11: reset state and unused indexes
    for (int a = 0; a < 16; a++)
      read_chk(a < 9 ? "R1" : "R11", a, a == 7 ? 32'h0765_4321 : 32'd0);
    chk("R1", "start_o", {25'd0, start_o}, 32'd0);
    chk("R1", "irq_o", {31'd0, irq_o}, 32'd0);

    // R2: priority word readback
    step("R2", 1, 7, 32'hFFFF_FFFF, 0); read_chk("R2", 7, 32'hFFFF_FFFF);
    step("R2", 1, 7, 32'h5A5A_A5A5, 0); read_chk("R2", 7, 32'h5A5A_A5A5);
    step("R2", 1, 7, 32'h0000_0000, 0); read_chk("R2", 7, 32'h0000_0000);

    // R8 / R10: start decision sweep over channel, enable and run bit
    for (int ch = 0; ch < 7; ch++) begin
      for (int en = 0; en < 2; en++) begin
        for (int b = 0; b < 2; b++) begin
          logic [31:0] pv;
          string tg;
          tg = (ch == 5) ? "R10" : "R8";
          pv = (32'h1 << (3 + 4*ch));
          if (en == 0) pv = ~pv;
          step("R8", 1, 7, pv, 0);
          step(tg, 1, ch, (b == 1 ? 32'h0100_0000 : 32'd0) | (32'h100 + 32'h11 * ch), 0);
          read_chk(tg, ch, m_ctrl[ch]);
          step(tg, 0, 0, 0, 0);
        end
      end
    end

    // R9: done clears run bit; a same-cycle write wins
    step("R9", 1, 7, 32'hFFFF_FFFF, 0);
    for (int ch = 0; ch < 7; ch++) begin
      step("R9", 1, ch, 32'h0100_00FF, 0);
      step("R9", 0, 0, 0, 7'(1 << ch));
      read_chk("R9", ch, m_ctrl[ch]);
      step("R9", 1, ch, 32'h0100_0011, 7'(1 << ch));
      read_chk("R9", ch, m_ctrl[ch]);
      step("R9", 0, 0, 0, 7'(1 << ch));
      read_chk("R9", ch, m_ctrl[ch]);
    end

    // R3 / R6 / R7: write mask, bus error raises summary and one pulse
    step("R3", 1, 8, 32'h7F7F_7FC0, 0);
    step("R3", 1, 8, 32'hFFFF_FFFF, 0);
    step("R7", 0, 0, 0, 0);
    step("R6", 1, 8, 32'h0000_003F, 0);
    step("R3", 1, 8, 32'h0000_0015, 0);

    // R5: flags only with enable; R6/R7 summary and single pulse
    step("R5", 1, 8, 32'h007F_0000, 0);
    step("R5", 0, 0, 0, 7'h01);
    step("R7", 1, 8, 32'h00FF_0000, 0);
    step("R7", 0, 0, 0, 7'h08);
    step("R4", 1, 8, 32'h01FF_0000, 0);
    step("R6", 1, 8, 32'h08FF_0000, 0);
    step("R7", 0, 0, 0, 7'h40);
    step("R5", 1, 8, 32'h40FF_0000, 7'h40);
    step("R4", 1, 8, 32'h7FFF_0000, 0);
    step("R5", 1, 8, 32'h0080_0000, 0);
    step("R5", 0, 0, 0, 7'h7F);

    // R4 / R5: per-channel flag sweep with enables set
    step("R5", 1, 8, 32'h00FF_0000, 0);
    for (int ch = 0; ch < 7; ch++) begin
      step("R5", 0, 0, 0, 7'(1 << ch));
      step("R4", 1, 8, 32'h00FF_0000 | (32'h0100_0000 << ((ch + 3) % 7)), 0);
      step("R4", 1, 8, 32'h7FFF_0000, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule